// File: doc/BRIEF.md
# Interrupt-Pending Register Unit with Merged External Sources

This unit holds the software-controlled interrupt-pending bits of a hart. It serves register read, write, set and clear requests through two address views. The machine view exposes every implemented pending bit. The supervisor view is narrower and exposes only supervisor-level bits. The unit also drives the pending vector that the interrupt arbitration logic consumes.

The supervisor external pending position (bit 9) is fed from two places: a flop that software owns, and a live line from the external interrupt controller. A read returns the OR of the two. The read-modify-write path of set and clear requests sees only the software flop, so clearing bit 9 never masks an interrupt that the controller is still asserting. The machine external pending position (bit 11) mirrors its own line directly and cannot be written.

A request is presented for one cycle with `req_valid` high. Read data and the illegal flag are combinational in that same cycle. Any state update takes effect at the following rising clock edge.

Top module: `ipend_csr_unit`

## Requirements
- R1: On a synchronous active-low reset every software pending bit clears, so the pending vector then shows only the external lines.
- R2: A legal machine-view access (address 0x344, privilege 3) returns in `rd_data` the software bits at positions 1, 5 and 9, with bit 9 ORed with `ext_seip` and bit 11 equal to `ext_meip`. All other bits read 0, and an idle cycle (`req_valid` low) returns 0.
- R3: Set (op 2) and clear (op 3) build the new stored value from the software bits only. A set of bit 1 while `ext_seip` is high leaves software bit 9 at 0.
- R4: For set and clear, `rd_data` is the merged value sampled before the update.
- R5: After a machine-view clear of bit 9 while `ext_seip` stays high, both reads and `pend_vec` still show bit 9 as 1. Once the line drops, bit 9 reads 0.
- R6: A supervisor-view access (address 0x144, privilege 1 or 2) reads only positions 1, 5 and 9. Of these, only bit 1 can be changed through this view.
- R7: The following requests assert `illegal` and return 0 in `rd_data`, with no state change: a machine-view request at privilege below 3, a supervisor-view request at privilege 0, and a request to any other address.
- R8: When `src_is_x0` is high, set and clear write nothing but still return the merged value. A write (op 1) still writes.
- R9: Bit 11 ignores every write, set and clear, and always equals `ext_meip`.
- R10: `pend_vec` follows the external lines combinationally, in the same cycle as a change on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| csr_addr | input | ADDR_W | Register address |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| src_data | input | XLEN | Source operand or mask |
| src_is_x0 | input | 1 | The source register is x0 |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| ext_seip | input | 1 | Supervisor external interrupt line from the controller |
| ext_meip | input | 1 | Machine external interrupt line from the controller |
| rd_data | output | XLEN | Read data (pre-update value) |
| illegal | output | 1 | The request was rejected |
| pend_vec | output | XLEN | Merged pending vector sent to arbitration |

## Verification
The bench builds the unit with its defaults: 32-bit data, 12-bit addresses, and view addresses 0x344 and 0x144. With these values every implemented bit position (1, 5, 9 and 11) lies inside the word, and an all-ones source shows which bits each view can actually change. The sequences of interest drive `ext_seip` high around set and clear requests, so that the software-only update path and the merged read path give different answers. Those answers are then confirmed by reads taken after the line drops.

// File: rtl/ipend_pkg.sv
// Package: shared bit positions, operation and privilege encodings for the
// interrupt-pending register unit. Assumes a data width of at least 12 bits.
package ipend_pkg;
    localparam int SSIP_POS = 1;
    localparam int STIP_POS = 5;
    localparam int SEIP_POS = 9;
    localparam int MEIP_POS = 11;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;
endpackage

// File: rtl/ipend_access.sv
// Module: decodes the address and privilege of a request into a machine-view
// hit, a supervisor-view hit, or a rejection. Assumes at most one of the two
// view addresses matches a given address.
module ipend_access #(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] MVIEW_ADDR = 12'h344,
    parameter logic [ADDR_W-1:0] SVIEW_ADDR = 12'h144
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] addr,
    input  ipend_pkg::priv_e  priv,
    output logic              hit_m,
    output logic              hit_s,
    output logic              reject
);
    import ipend_pkg::*;

    // Classify the request by view and privilege.
    always_comb begin
        hit_m  = req_valid && (addr == MVIEW_ADDR) && (priv == PRIV_M);
        hit_s  = req_valid && (addr == SVIEW_ADDR) && (priv != PRIV_U);
        reject = req_valid && !hit_m && !hit_s;
    end
endmodule

// File: rtl/ipend_swreg.sv
// Module: owns the software-writable pending flops (SSIP, STIP, SEIP) and
// performs write/set/clear on them. Assumes that at most one of hit_m and
// hit_s is high. The old value of read-modify-write is the software state
// only; the external lines never enter this path.
module ipend_swreg #(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_m,
    input  logic                hit_s,
    input  ipend_pkg::csr_op_e  op,
    input  logic [XLEN-1:0]     src,
    input  logic                src_is_x0,
    output logic [XLEN-1:0]     sw_q
);
    import ipend_pkg::*;

    localparam logic [XLEN-1:0] M_WMASK = (XLEN'(1) << SSIP_POS)
                                        | (XLEN'(1) << STIP_POS)
                                        | (XLEN'(1) << SEIP_POS);
    localparam logic [XLEN-1:0] S_WMASK = (XLEN'(1) << SSIP_POS);

    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] cand;
    logic [XLEN-1:0] sw_d;
    logic            do_wr;

    // Form the candidate value and the view-dependent write mask.
    always_comb begin
        wmask = hit_m ? M_WMASK : (hit_s ? S_WMASK : '0);
        case (op)
            OP_WRITE: cand = src;
            OP_SET:   cand = sw_q | src;
            OP_CLEAR: cand = sw_q & ~src;
            default:  cand = sw_q;
        endcase
        do_wr = (hit_m || hit_s)
             && ((op == OP_WRITE) || (((op == OP_SET) || (op == OP_CLEAR)) && !src_is_x0));
        sw_d  = do_wr ? ((sw_q & ~wmask) | (cand & wmask)) : sw_q;
    end

    // Hold the software pending bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_d;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sw_q == '0));

    assert_clear_swonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_m && op == OP_CLEAR && !src_is_x0 && src[SEIP_POS]) |=> !sw_q[SEIP_POS]);

    assert_sview_ro_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_s |=> (sw_q[SEIP_POS] == $past(sw_q[SEIP_POS]))
               && (sw_q[STIP_POS] == $past(sw_q[STIP_POS])));

    assert_reject_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_m && !hit_s) |=> $stable(sw_q));

    assert_x0_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_m || hit_s) && (op == OP_SET || op == OP_CLEAR) && src_is_x0) |=> $stable(sw_q));

    assert_meip_not_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_q[MEIP_POS]);
endmodule

// File: rtl/ipend_merge.sv
// Module: merges the software bits with the external lines into the pending
// vector and selects the read data for the active view. Purely combinational.
module ipend_merge #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] sw_q,
    input  logic            ext_seip,
    input  logic            ext_meip,
    input  logic            hit_m,
    input  logic            hit_s,
    output logic [XLEN-1:0] pend,
    output logic [XLEN-1:0] rdata
);
    import ipend_pkg::*;

    localparam logic [XLEN-1:0] S_RMASK = (XLEN'(1) << SSIP_POS)
                                        | (XLEN'(1) << STIP_POS)
                                        | (XLEN'(1) << SEIP_POS);

    // OR the live lines into their positions and pick the view's read value.
    always_comb begin
        pend = sw_q
             | (XLEN'(ext_seip) << SEIP_POS)
             | (XLEN'(ext_meip) << MEIP_POS);
        rdata = hit_m ? pend : (hit_s ? (pend & S_RMASK) : '0);
    end
endmodule

// File: rtl/ipend_csr_unit.sv
// Module: top of the interrupt-pending register unit. Decodes the request,
// updates the software pending bits and merges them with the external lines.
// Read data and the reject flag are combinational; state changes at the next
// rising edge. Reset is synchronous and active low.
module ipend_csr_unit #(
    parameter int                XLEN       = 32,
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] MVIEW_ADDR = 12'h344,
    parameter logic [ADDR_W-1:0] SVIEW_ADDR = 12'h144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [1:0]        csr_op,
    input  logic [XLEN-1:0]   src_data,
    input  logic              src_is_x0,
    input  logic [1:0]        priv_lvl,
    input  logic              ext_seip,
    input  logic              ext_meip,
    output logic [XLEN-1:0]   rd_data,
    output logic              illegal,
    output logic [XLEN-1:0]   pend_vec
);
    import ipend_pkg::*;

    logic            hit_m;
    logic            hit_s;
    logic [XLEN-1:0] sw_q;

    ipend_access #(
        .ADDR_W(ADDR_W), .MVIEW_ADDR(MVIEW_ADDR), .SVIEW_ADDR(SVIEW_ADDR)
    ) u_access (
        .req_valid(req_valid),
        .addr     (csr_addr),
        .priv     (priv_e'(priv_lvl)),
        .hit_m    (hit_m),
        .hit_s    (hit_s),
        .reject   (illegal)
    );

    ipend_swreg #(.XLEN(XLEN)) u_swreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_m    (hit_m),
        .hit_s    (hit_s),
        .op       (csr_op_e'(csr_op)),
        .src      (src_data),
        .src_is_x0(src_is_x0),
        .sw_q     (sw_q)
    );

    ipend_merge #(.XLEN(XLEN)) u_merge (
        .sw_q    (sw_q),
        .ext_seip(ext_seip),
        .ext_meip(ext_meip),
        .hit_m   (hit_m),
        .hit_s   (hit_s),
        .pend    (pend_vec),
        .rdata   (rd_data)
    );

    assert_mread_seip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && csr_addr == MVIEW_ADDR && priv_lvl == 2'd3 && ext_seip)
            |-> rd_data[SEIP_POS]);

    assert_ext_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_seip |-> pend_vec[SEIP_POS]);

    assert_mview_lowpriv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && csr_addr == MVIEW_ADDR && priv_lvl != 2'd3)
            |-> (illegal && rd_data == '0));

    assert_meip_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vec[MEIP_POS] == ext_meip);
endmodule

// File: tb/sim_ipend_csr_unit.sv
// Bench: scoreboard. The driver applies one request per cycle at the falling
// edge and pushes the expected outputs; the monitor pops and compares shortly
// after that edge, before the next rising edge.
module sim_ipend_csr_unit;
    localparam int   XLEN   = 32;
    localparam int   PERIOD = 10;
    localparam logic [11:0] MA = 12'h344;
    localparam logic [11:0] SA = 12'h144;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [1:0]      csr_op = '0;
    logic [XLEN-1:0] src_data = '0;
    logic            src_is_x0 = 1'b0;
    logic [1:0]      priv_lvl = 2'd3;
    logic            ext_seip = 1'b0;
    logic            ext_meip = 1'b0;
    logic [XLEN-1:0] rd_data;
    logic            illegal;
    logic [XLEN-1:0] pend_vec;

    ipend_csr_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .csr_addr(csr_addr),
        .csr_op(csr_op), .src_data(src_data), .src_is_x0(src_is_x0),
        .priv_lvl(priv_lvl), .ext_seip(ext_seip), .ext_meip(ext_meip),
        .rd_data(rd_data), .illegal(illegal), .pend_vec(pend_vec)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [XLEN-1:0] rd;
        logic            ill;
        logic [XLEN-1:0] pend;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;

    // Reference software bits: 1 = SSIP, 5 = STIP, 9 = SEIP.
    logic [XLEN-1:0] mdl_sw = '0;

    // Apply one request and push the expected outputs for this cycle.
    task automatic apply(input string tag, input bit v, input logic [11:0] a,
                         input logic [1:0] op, input logic [XLEN-1:0] s,
                         input bit x0, input logic [1:0] pv,
                         input bit es, input bit em);
        exp_t e;
        bit lm, ls;
        logic [XLEN-1:0] merged, wm, cand;
        @(negedge clk);
        req_valid = v; csr_addr = a; csr_op = op; src_data = s;
        src_is_x0 = x0; priv_lvl = pv; ext_seip = es; ext_meip = em;
        lm = v && a == MA && pv == 2'd3;
        ls = v && a == SA && pv != 2'd0;
        merged = mdl_sw | (XLEN'(es) << 9) | (XLEN'(em) << 11);
        e.pend = merged;
        e.ill  = v && !lm && !ls;
        e.rd   = lm ? merged : (ls ? (merged & 32'h222) : '0);
        expq.push_back(e);
        tagq.push_back(tag);
        if ((lm || ls) && (op == 2'd1 || (op >= 2'd2 && !x0))) begin
            wm = lm ? 32'h222 : 32'h002;
            case (op)
                2'd1:    cand = s;
                2'd2:    cand = mdl_sw | s;
                default: cand = mdl_sw & ~s;
            endcase
            mdl_sw = (mdl_sw & ~wm) | (cand & wm);
        end
    endtask

    // Monitor: compare the design's outputs against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                n_chk++;
                if (rd_data !== e.rd || illegal !== e.ill || pend_vec !== e.pend) begin
                    n_bad++;
                    $display("FAIL %s: rd=%h ill=%b pend=%h expected rd=%h ill=%b pend=%h",
                             t, rd_data, illegal, pend_vec, e.rd, e.ill, e.pend);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset, idle cycle reads 0
        apply("R1", 0, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R10: pending vector follows lines in the same cycle
        apply("R10", 0, MA, 2'd0, '0, 0, 2'd3, 1, 1);
        apply("R10", 0, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R2: machine write all ones, read back only implemented bits
        apply("R2", 1, MA, 2'd1, '1, 0, 2'd3, 0, 0);
        apply("R2", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R9: bit 11 follows its line and ignores writes
        apply("R9", 1, MA, 2'd0, '0, 0, 2'd3, 0, 1);
        apply("R9", 1, MA, 2'd3, '1, 0, 2'd3, 0, 1);
        apply("R9", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R2: line alone shows in bit 9
        apply("R2", 1, MA, 2'd0, '0, 0, 2'd3, 1, 0);
        // R3/R4: set bit 1 while line high; rd is pre-update merged value
        apply("R4", 1, MA, 2'd2, 32'h2, 0, 2'd3, 1, 0);
        apply("R3", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R5: software bit 9 set, then cleared while line stays high
        apply("R5", 1, MA, 2'd2, 32'h200, 0, 2'd3, 0, 0);
        apply("R4", 1, MA, 2'd3, 32'h200, 0, 2'd3, 1, 0);
        apply("R5", 1, MA, 2'd0, '0, 0, 2'd3, 1, 0);
        apply("R5", 0, MA, 2'd0, '0, 0, 2'd3, 1, 0);
        apply("R5", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R8: x0 source blocks set/clear, not write
        apply("R8", 1, MA, 2'd3, 32'h2, 1, 2'd3, 1, 0);
        apply("R8", 1, MA, 2'd2, '1, 1, 2'd3, 0, 0);
        apply("R8", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        apply("R8", 1, MA, 2'd1, '0, 1, 2'd3, 0, 0);
        apply("R8", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R6: supervisor view masking and read-only bits
        apply("R6", 1, MA, 2'd1, 32'h222, 0, 2'd3, 0, 1);
        apply("R6", 1, SA, 2'd0, '0, 0, 2'd1, 0, 1);
        apply("R6", 1, SA, 2'd3, 32'h222, 0, 2'd1, 0, 1);
        apply("R6", 1, MA, 2'd0, '0, 0, 2'd3, 0, 1);
        apply("R6", 1, SA, 2'd1, '0, 0, 2'd1, 1, 0);
        apply("R6", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        apply("R6", 1, SA, 2'd2, '1, 0, 2'd1, 0, 0);
        apply("R6", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R7: rejected requests change nothing
        apply("R7", 1, MA, 2'd1, '0, 0, 2'd1, 0, 0);
        apply("R7", 1, MA, 2'd3, '1, 0, 2'd0, 0, 0);
        apply("R7", 1, SA, 2'd1, '0, 0, 2'd0, 0, 0);
        apply("R7", 1, 12'h300, 2'd1, '0, 0, 2'd3, 0, 0);
        apply("R7", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        // R1: reset clears software bits again
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mdl_sw = '0;
        apply("R1", 1, MA, 2'd0, '0, 0, 2'd3, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule